// File: doc/BRIEF.md
# Stop-Mode Power Handshake Controller

This block controls how a processor core enters and leaves its software stop mode, a deep power-down state in which the core clock is halted. Software writes a stop bit. The controller then asks the external memory controller to quiesce and waits for its acknowledge. Only after the acknowledge does it ask the clock-control circuit to halt the core clock.

While the core is stopped, a combinational wake detector watches three kinds of source:
- the non-maskable interrupt lines,
- the maskable interrupt lines whose mask bit is clear,
- a reset-type wake input, held by a level latch so that it may arrive with no clock running.

A wake event drops the clock stop request so that the clock generator restarts. The controller then waits for the clock-ready level that comes back with the core clock. When it sees that level, it releases the memory request and clears the stop bit. A new stop sequence cannot begin until clock-ready has been seen low again.

Top module: `stop_handshake_ctrl`

## Requirements
- R1: A one-cycle pulse on `stop_wr` sets `stop_bit` after the next rising edge. `mem_stop_req` then rises after the second rising edge following the pulse. It stays high until clock-ready is accepted (R5).
- R2: `clk_stop_req` stays low while `mem_stop_ack` is low. It rises after the first rising edge at which `mem_stop_ack` is sampled high with `mem_stop_req` high.
- R3: While stopped, a wake is any of the following:
    - any bit of `nmi_req` high;
    - any bit `i` with `irq_req[i]` high and `irq_mask[i]` low (a mask bit of 1 blocks that line);
    - `ext_wake` high.
  A masked interrupt alone leaves `clk_stop_req` high.
- R4: When a wake appears in the stopped state between two edges, `clk_stop_req` falls after the third following rising edge. This is two synchroniser stages plus the state register.
- R5: After the wake, `clk_stop_req` stays low and `mem_stop_req` stays high until `clk_ready` is sampled high at a rising edge. After that edge `mem_stop_req` is low and `stop_bit` is cleared.
- R6: `clk_ready` held high for a single clock cycle is accepted.
- R7: A stop bit written while `clk_ready` is still high does not start a new entry. `mem_stop_req` rises only after the second rising edge after `clk_ready` is first sampled low.
- R8: An `ext_wake` pulse that is high only between two clock edges, during the stopped state, is latched and ends stop mode with the R4 timing.
- R9: Wake events during the wait for the memory acknowledge are ignored, latched `ext_wake` pulses included. If they are gone by the time the stopped state is reached, the core stays stopped.
- R10: After reset, `stop_bit`, `mem_stop_req` and `clk_stop_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_wr | input | 1 | Register write pulse that sets the stop bit |
| stop_bit | output | 1 | Current value of the stop bit |
| mem_stop_req | output | 1 | Stop request to the memory controller |
| mem_stop_ack | input | 1 | Acknowledge from the memory controller |
| clk_stop_req | output | 1 | Request to the clock-control circuit to halt the core clock |
| clk_ready | input | 1 | Clock-ready level returned with the core clock |
| nmi_req | input | NMI_N | Non-maskable interrupt wake lines |
| irq_req | input | IRQ_N | Maskable interrupt wake lines |
| irq_mask | input | IRQ_N | Per-line mask, 1 blocks the line |
| ext_wake | input | 1 | Reset-type wake input, level latched |

## Verification
The bench uses the default parameters: 3 non-maskable lines, 64 maskable lines and two synchroniser stages. Random line indices therefore reach both ends of the wide interrupt vector, and the three-edge wake latency is fixed and can be predicted exactly. Random acknowledge delays, clock-ready delays and clock-ready widths cover the single-cycle clock-ready case. Directed passes cover a sub-cycle `ext_wake` pulse, wakes that arrive before the acknowledge, and a stop write made while clock-ready is still high.

// File: rtl/stop_hs_pkg.sv
// Package: shared state encoding for the stop-mode handshake controller.
// Assumes: consumers import it before declaring state registers.
package stop_hs_pkg;
    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_WAIT_ACK  = 3'd1,
        ST_STOPPED   = 3'd2,
        ST_WAIT_CLK  = 3'd3,
        ST_WAIT_LOW  = 3'd4
    } stop_state_e;
endpackage

// File: rtl/stop_ctrl_reg.sv
// Module: stop_ctrl_reg
// Holds the software stop bit. A write pulse sets it; the sequencer clears it
// when stop mode ends. Assumes a write and a clear in the same cycle favour
// the write, so a fresh request is never lost.
module stop_ctrl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_wr,
    input  logic stop_done,
    output logic stop_bit
);
    // Stop bit: set on write, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)         stop_bit <= 1'b0;
        else if (stop_wr)   stop_bit <= 1'b1;
        else if (stop_done) stop_bit <= 1'b0;
    end

    // A write always leaves the bit set afterwards.
    assert_wr_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> stop_bit);
endmodule

// File: rtl/stop_wake_detect.sv
// Module: stop_wake_detect
// Combines the wake sources into one level, latches the reset-type input
// asynchronously, and synchronises the result into the core clock domain.
// Assumes `arm` is high only in the stopped state; outside it the latch and
// the synchroniser are held clear so stale events are discarded.
module stop_wake_detect #(
    parameter int NMI_N       = 3,
    parameter int IRQ_N       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [NMI_N-1:0] nmi_req,
    input  logic [IRQ_N-1:0] irq_req,
    input  logic [IRQ_N-1:0] irq_mask,
    input  logic             ext_wake,
    output logic             wake_sync
);
    localparam int SW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    logic          ext_lat;
    logic          wake_raw;
    logic [SW-1:0] sync_q;

    // Level latch for the reset-type wake: set by the input, cleared when disarmed.
    always_latch begin
        if (!arm)          ext_lat = 1'b0;
        else if (ext_wake) ext_lat = 1'b1;
    end

    // Combinational wake: works without a running clock.
    always_comb begin
        wake_raw = (|nmi_req) | (|(irq_req & ~irq_mask)) | ext_lat;
    end

    // Synchroniser chain, flushed whenever the detector is disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) sync_q <= '0;
        else                sync_q <= (sync_q << 1) | SW'(wake_raw);
    end

    assign wake_sync = sync_q[SW-1];

    // The synchronised wake can only exist after an armed cycle.
    assert_sync_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_sync) |-> $past(arm));
endmodule

// File: rtl/stop_seq_fsm.sv
// Module: stop_seq_fsm
// Sequences stop entry (memory handshake, then clock stop) and exit (clock
// release, wait for clock-ready, wait for clock-ready low). Assumes mem_ack
// and clk_ready are synchronous to clk and the wake input is already synchronised.
module stop_seq_fsm
    import stop_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_bit,
    input  logic mem_ack,
    input  logic wake,
    input  logic clk_ready,
    output logic mem_req,
    output logic clk_req,
    output logic arm,
    output logic stop_done
);
    stop_state_e state_q, state_d;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (stop_bit && !clk_ready) state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: if (mem_ack)                state_d = ST_STOPPED;
            ST_STOPPED:  if (wake)                   state_d = ST_WAIT_CLK;
            ST_WAIT_CLK: if (clk_ready)              state_d = ST_WAIT_LOW;
            ST_WAIT_LOW: if (!clk_ready)             state_d = ST_RUN;
            default:                                 state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Output decode from the current state.
    always_comb begin
        mem_req   = (state_q == ST_WAIT_ACK) || (state_q == ST_STOPPED) ||
                    (state_q == ST_WAIT_CLK);
        clk_req   = (state_q == ST_STOPPED);
        arm       = (state_q == ST_STOPPED);
        stop_done = (state_q == ST_WAIT_CLK) && clk_ready;
    end

    assert_memreq_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !clk_ready) |=> mem_req);
    assert_clkreq_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_req) |-> $past(mem_ack) && $past(mem_req));
    assert_clkreq_drop_on_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_req) |-> $past(wake));
    assert_memreq_drop_on_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> $past(clk_ready));
    assert_entry_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !$past(clk_ready));
endmodule

// File: rtl/stop_handshake_ctrl.sv
// Module: stop_handshake_ctrl (top)
// Software stop-mode controller: stop bit, memory stop handshake, clock stop
// request and wake detection. Assumes the clock-control and memory
// controller drive their inputs synchronously to clk, except ext_wake.
module stop_handshake_ctrl #(
    parameter int NMI_N       = 3,
    parameter int IRQ_N       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_wr,
    output logic             stop_bit,
    output logic             mem_stop_req,
    input  logic             mem_stop_ack,
    output logic             clk_stop_req,
    input  logic             clk_ready,
    input  logic [NMI_N-1:0] nmi_req,
    input  logic [IRQ_N-1:0] irq_req,
    input  logic [IRQ_N-1:0] irq_mask,
    input  logic             ext_wake
);
    logic stop_done;
    logic arm;
    logic wake_sync;

    stop_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_wr   (stop_wr),
        .stop_done (stop_done),
        .stop_bit  (stop_bit)
    );

    stop_wake_detect #(
        .NMI_N       (NMI_N),
        .IRQ_N       (IRQ_N),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .nmi_req   (nmi_req),
        .irq_req   (irq_req),
        .irq_mask  (irq_mask),
        .ext_wake  (ext_wake),
        .wake_sync (wake_sync)
    );

    stop_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_bit  (stop_bit),
        .mem_ack   (mem_stop_ack),
        .wake      (wake_sync),
        .clk_ready (clk_ready),
        .mem_req   (mem_stop_req),
        .clk_req   (clk_stop_req),
        .arm       (arm),
        .stop_done (stop_done)
    );

    // Clock stop is never requested without the memory request.
    assert_clk_implies_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_req |-> mem_stop_req);
endmodule

// File: tb/stop_handshake_ctrl_bench.sv
// Bench: random and directed stop/wake sequences against bench-computed expectations.
module stop_handshake_ctrl_bench;
    localparam int NMI_N = 3;
    localparam int IRQ_N = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stop_wr = 1'b0;
    logic             stop_bit, mem_stop_req, clk_stop_req;
    logic             mem_stop_ack = 1'b0;
    logic             clk_ready = 1'b0;
    logic [NMI_N-1:0] nmi_req = '0;
    logic [IRQ_N-1:0] irq_req = '0;
    logic [IRQ_N-1:0] irq_mask = '0;
    logic             ext_wake = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stop_handshake_ctrl #(.NMI_N(NMI_N), .IRQ_N(IRQ_N), .SYNC_STAGES(2)) u_stop_handshake_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_wr(stop_wr), .stop_bit(stop_bit),
        .mem_stop_req(mem_stop_req), .mem_stop_ack(mem_stop_ack),
        .clk_stop_req(clk_stop_req), .clk_ready(clk_ready),
        .nmi_req(nmi_req), .irq_req(irq_req), .irq_mask(irq_mask), .ext_wake(ext_wake)
    );

    function automatic bit wake_expected(logic [NMI_N-1:0] n, logic [IRQ_N-1:0] i,
                                         logic [IRQ_N-1:0] m, logic e);
        return (|n) || (|(i & ~m)) || e;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Enter stop mode from RUN; leaves the core in the stopped state.
    task automatic enter_stop(int ack_dly, bit noise);
        stop_wr = 1'b1;
        tick(1);
        stop_wr = 1'b0;
        chk("R1 stop_bit set", stop_bit, 1);
        chk("R1 mem req not yet", mem_stop_req, 0);
        tick(1);
        chk("R1 mem req up", mem_stop_req, 1);
        for (int k = 0; k < ack_dly; k++) begin
            if (noise) begin
                nmi_req[$urandom % NMI_N] = 1'b1;
                #3 ext_wake = 1'b1;
                #3 ext_wake = 1'b0;
            end
            tick(1);
            nmi_req = '0;
            chk("R2 no clk req before ack", clk_stop_req, 0);
        end
        mem_stop_ack = 1'b1;
        tick(1);
        chk("R2 clk req after ack", clk_stop_req, 1);
    endtask

    // Wake already applied at this negedge; check the three-edge latency.
    task automatic check_wake_latency(string req);
        tick(2);
        chk(req, clk_stop_req, 1);
        tick(1);
        chk(req, clk_stop_req, 0);
        nmi_req = '0;
        irq_req = '0;
        ext_wake = 1'b0;
    endtask

    // Return clock-ready after a delay and hold it for a width.
    task automatic finish_exit(int rdy_dly, int width);
        for (int k = 0; k < rdy_dly; k++) begin
            tick(1);
            chk("R5 mem req held", mem_stop_req, 1);
        end
        clk_ready = 1'b1;
        tick(1);
        chk("R5 mem req released", mem_stop_req, 0);
        chk("R5 stop bit cleared", stop_bit, 0);
        mem_stop_ack = 1'b0;
        if (width > 0) tick(width);
        clk_ready = 1'b0;
        tick(1);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        tick(3);
        chk("R10 stop_bit reset", stop_bit, 0);
        chk("R10 mem req reset", mem_stop_req, 0);
        chk("R10 clk req reset", clk_stop_req, 0);
        rst_n = 1'b1;
        tick(1);

        // R6: single-cycle clock-ready, NMI wake on the top line.
        enter_stop(2, 1'b0);
        nmi_req[NMI_N-1] = 1'b1;
        check_wake_latency("R4 nmi wake latency");
        finish_exit(0, 0);
        chk("R6 back to idle", mem_stop_req, 0);

        // R9: wakes during ack wait are dropped; core stays stopped.
        enter_stop(3, 1'b1);
        tick(6);
        chk("R9 stale wake ignored", clk_stop_req, 1);
        // R8: sub-cycle ext_wake pulse in the stopped state.
        #3 ext_wake = 1'b1;
        #3 ext_wake = 1'b0;
        check_wake_latency("R8 ext pulse wake");
        finish_exit(1, 1);

        // R7: stop write while clock-ready high.
        enter_stop(0, 1'b0);
        irq_req[IRQ_N-1] = 1'b1;
        check_wake_latency("R4 irq wake latency");
        clk_ready = 1'b1;
        tick(1);
        mem_stop_ack = 1'b0;
        stop_wr = 1'b1;
        tick(1);
        stop_wr = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick(1);
            chk("R7 no entry while ready high", mem_stop_req, 0);
        end
        clk_ready = 1'b0;
        tick(1);
        chk("R7 still waiting", mem_stop_req, 0);
        tick(1);
        chk("R7 entry after ready low", mem_stop_req, 1);
        mem_stop_ack = 1'b1;
        tick(1);
        chk("R2 clk req after ack", clk_stop_req, 1);
        ext_wake = 1'b1;
        check_wake_latency("R3 ext level wake");
        finish_exit(0, 0);

        // Random sequences.
        for (int it = 0; it < 60; it++) begin
            int kind;
            int idx;
            enter_stop($urandom % 5, $urandom % 2);
            kind = $urandom % 4;
            case (kind)
                0: nmi_req[$urandom % NMI_N] = 1'b1;
                1: begin
                    idx = $urandom % IRQ_N;
                    irq_req[idx] = 1'b1;
                    irq_mask = '0;
                    irq_mask[idx] = $urandom % 2;
                end
                default: ext_wake = 1'b1;
            endcase
            if (!wake_expected(nmi_req, irq_req, irq_mask, ext_wake)) begin
                tick(6);
                chk("R3 masked irq no wake", clk_stop_req, 1);
                irq_mask = '0;
            end
            if (kind == 2) begin
                #3 ext_wake = 1'b0;
            end
            check_wake_latency("R4 random wake latency");
            irq_mask = '0;
            finish_exit($urandom % 6, $urandom % 3);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule